// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block is one general-purpose I/O port of up to 32 pins, reached through a simple register bus with per-byte write strobes. Each pin has its own direction bit, and that bit drives the pad output enable. Software can load the output value in four ways. It can write the whole word. It can make a write that a protect mask limits. It can use a write-one-to-set register or a write-one-to-clear register. Every pad input passes through a synchronizer. The live pin level can be read back whatever the pin direction.

Each pin can raise its own interrupt. In edge mode, a rising or falling transition latches a status bit that stays set until software writes one to clear it. In level mode, the request follows the synchronized pin while it matches the chosen polarity. The port also drives one group interrupt. This interrupt combines a selected set of pins, each compared against its own active level, with either AND or OR.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction, output, mask and all interrupt configuration registers are zero, so pad_oe, pad_out, pin_irq and group_irq are all low.
- R2: Bit n of the direction register (byte offset 0x00) drives pad_oe[n]: 1 makes the pin an output.
- R3: A write to the output register (offset 0x04) replaces only the byte lanes whose bus_be bit is 1. Every register takes byte and half-word writes this way. The output register reads back through offset 0x04 and appears on pad_out.
- R4: A write to the masked-output address (offset 0x0C) changes only the output bits that are strobed and have a 0 in the protect mask register (offset 0x08). Bits with a mask value of 1 keep their value.
- R5: Writing to offset 0x10 sets every output bit written as 1 in a strobed lane. Zero bits and unstrobed lanes leave the outputs unchanged.
- R6: Writing to offset 0x14 clears every output bit written as 1 in a strobed lane. Zero bits and unstrobed lanes leave the outputs unchanged.
- R7: The pin register (offset 0x18) returns the pad level two clock edges after it changes, regardless of direction.
- R8: A pin with its enable bit set (offset 0x1C), mode bit 0 (offset 0x20, 0 = edge) and polarity bit 1 (offset 0x24, 1 = rising) sets its status bit (offset 0x28) on the third clock edge after a rising pad transition. With polarity 0, a falling transition sets it instead. The bit stays set until a one is written to it at offset 0x28.
- R9: With mode bit 1 (level), the pin's request and status bit are high whenever the synchronized pin equals its polarity bit (1 = high active), and they follow the pin.
- R10: Group interrupt: the pins selected at offset 0x2C are each active when their level equals the bit at offset 0x30. When bit 0 of offset 0x34 is 0 (OR), group_irq is high if any selected pin is active.
- R11: When bit 0 of offset 0x34 is 1 (AND), group_irq is high only when every selected pin is active. With no pins selected it stays low.
- R12: pin_irq[n] is low while enable bit n is 0. A latched edge status bit still reads back as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 1 pick the register |
| bus_be | input | WIDTH/8 | Byte-lane write strobes |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the addressed register |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Output data to the pads |
| pad_oe | output | WIDTH | Pad output enables |
| pin_irq | output | WIDTH | Per-pin interrupt requests |
| group_irq | output | 1 | Combined group interrupt |

## Verification
The output register is tested with full-word, single-byte and half-word strobes. It is also tested with masked writes whose protect mask covers some of the written lanes. Set and clear writes are tested with zero bits and with unstrobed lanes, so that the test separates "bit written as zero" from "lane not strobed". Edge interrupts are driven with both polarities, with the wrong transition first and then the right one, and status is sampled one edge early and then on time. Level mode is tested by moving a pin in and out of its active level. The group interrupt is tested with the same pin pattern under OR, AND, a changed polarity and an empty selection.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [3:0] {
      RIX_DIR   = 4'd0,
      RIX_OUT   = 4'd1,
      RIX_MASK  = 4'd2,
      RIX_MOUT  = 4'd3,
      RIX_SET   = 4'd4,
      RIX_CLR   = 4'd5,
      RIX_PIN   = 4'd6,
      RIX_IEN   = 4'd7,
      RIX_IMODE = 4'd8,
      RIX_IPOL  = 4'd9,
      RIX_ISTAT = 4'd10,
      RIX_GSEL  = 4'd11,
      RIX_GPOL  = 4'd12,
      RIX_GCTL  = 4'd13
   } reg_idx_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
   parameter int WIDTH     = 32,
   parameter bit GROUP_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] en,
   input  logic [WIDTH-1:0] mode,
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] w1c,
   input  logic [WIDTH-1:0] gsel,
   input  logic [WIDTH-1:0] gpol,
   input  logic             gand,
   output logic [WIDTH-1:0] stat,
   output logic [WIDTH-1:0] pin_irq,
   output logic             group_irq
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] sticky_q;
   logic [WIDTH-1:0] ev_vec;
   logic [WIDTH-1:0] lvl_hit;
   logic [WIDTH-1:0] g_active;
   logic             group_comb;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall;
      assign rise       = lvl[i] & ~prev_q[i];
      assign fall       = ~lvl[i] & prev_q[i];
      assign ev_vec[i]  = en[i] & ~mode[i] & (pol[i] ? rise : fall);
      assign lvl_hit[i] = en[i] & mode[i] & (lvl[i] == pol[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         sticky_q <= '0;
      end else begin
         prev_q   <= lvl;
         sticky_q <= (sticky_q & ~w1c) | ev_vec;
      end
   end

   assign stat    = sticky_q | lvl_hit;
   assign pin_irq = (sticky_q & en & ~mode) | lvl_hit;

   assign g_active   = gsel & ~(lvl ^ gpol);
   assign group_comb = gand ? ((gsel != '0) && (g_active == gsel)) : (|g_active);

   if (GROUP_REG) begin : g_grp_reg
      logic grp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) grp_q <= 1'b0;
         else        grp_q <= group_comb;
      end
      assign group_irq = grp_q;
   end else begin : g_grp_comb
      assign group_irq = group_comb;
   end

   assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c == '0) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

   assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c != '0) |=> ((sticky_q & $past(w1c) & ~$past(ev_vec)) == '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit GROUP_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [WIDTH/8-1:0]   bus_be,
   input  logic [WIDTH-1:0]     bus_wdata,
   output logic [WIDTH-1:0]     bus_rdata,
   input  logic [WIDTH-1:0]     pad_in,
   output logic [WIDTH-1:0]     pad_out,
   output logic [WIDTH-1:0]     pad_oe,
   output logic [WIDTH-1:0]     pin_irq,
   output logic                 group_irq
);

   localparam int LANES = WIDTH / 8;
   localparam int IDX_W = ADDR_W - 2;

   if ((WIDTH % 8) != 0 || WIDTH < 8 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port_ctrl: WIDTH must be 8, 16, 24 or 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_port_ctrl: ADDR_W must be at least 6");
   end

   logic [IDX_W-1:0] widx;
   logic             wr_en;
   logic [WIDTH-1:0] lane_m;
   logic [WIDTH-1:0] strobed;
   logic             unused_addr_lsb;

   assign widx            = bus_addr[ADDR_W-1:2];
   assign wr_en           = bus_sel & bus_wr;
   assign strobed         = bus_wdata & lane_m;
   assign unused_addr_lsb = ^bus_addr[1:0];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_m[8*l +: 8] = {8{bus_be[l]}};
   end

   function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old,
                                              input logic [WIDTH-1:0] lm,
                                              input logic [WIDTH-1:0] nw);
      return (old & ~lm) | (nw & lm);
   endfunction

   function automatic logic hit(input logic [IDX_W-1:0] ix, input reg_idx_e r, input logic we);
      return we && (ix == IDX_W'(r));
   endfunction

   logic [WIDTH-1:0] dir_q, out_q, mask_q, ien_q, imode_q, ipol_q, gsel_q, gpol_q;
   logic             gand_q;
   logic [WIDTH-1:0] out_d;
   logic [WIDTH-1:0] pin_lvl, istat, w1c;

   always_comb begin
      out_d = out_q;
      if (hit(widx, RIX_OUT, wr_en))  out_d = merge(out_q, lane_m, bus_wdata);
      if (hit(widx, RIX_MOUT, wr_en)) out_d = merge(out_q, lane_m & ~mask_q, bus_wdata);
      if (hit(widx, RIX_SET, wr_en))  out_d = out_q | strobed;
      if (hit(widx, RIX_CLR, wr_en))  out_d = out_q & ~strobed;
   end

   assign w1c = hit(widx, RIX_ISTAT, wr_en) ? strobed : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         out_q   <= '0;
         mask_q  <= '0;
         ien_q   <= '0;
         imode_q <= '0;
         ipol_q  <= '0;
         gsel_q  <= '0;
         gpol_q  <= '0;
         gand_q  <= 1'b0;
      end else begin
         out_q <= out_d;
         if (hit(widx, RIX_DIR, wr_en))   dir_q   <= merge(dir_q, lane_m, bus_wdata);
         if (hit(widx, RIX_MASK, wr_en))  mask_q  <= merge(mask_q, lane_m, bus_wdata);
         if (hit(widx, RIX_IEN, wr_en))   ien_q   <= merge(ien_q, lane_m, bus_wdata);
         if (hit(widx, RIX_IMODE, wr_en)) imode_q <= merge(imode_q, lane_m, bus_wdata);
         if (hit(widx, RIX_IPOL, wr_en))  ipol_q  <= merge(ipol_q, lane_m, bus_wdata);
         if (hit(widx, RIX_GSEL, wr_en))  gsel_q  <= merge(gsel_q, lane_m, bus_wdata);
         if (hit(widx, RIX_GPOL, wr_en))  gpol_q  <= merge(gpol_q, lane_m, bus_wdata);
         if (hit(widx, RIX_GCTL, wr_en) && bus_be[0]) gand_q <= bus_wdata[0];
      end
   end

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_lvl)
   );

   gpio_irq #(.WIDTH(WIDTH), .GROUP_REG(GROUP_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (pin_lvl),
      .en        (ien_q),
      .mode      (imode_q),
      .pol       (ipol_q),
      .w1c       (w1c),
      .gsel      (gsel_q),
      .gpol      (gpol_q),
      .gand      (gand_q),
      .stat      (istat),
      .pin_irq   (pin_irq),
      .group_irq (group_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (widx == IDX_W'(RIX_DIR))        bus_rdata = dir_q;
      else if (widx == IDX_W'(RIX_OUT))   bus_rdata = out_q;
      else if (widx == IDX_W'(RIX_MASK))  bus_rdata = mask_q;
      else if (widx == IDX_W'(RIX_MOUT))  bus_rdata = out_q;
      else if (widx == IDX_W'(RIX_PIN))   bus_rdata = pin_lvl;
      else if (widx == IDX_W'(RIX_IEN))   bus_rdata = ien_q;
      else if (widx == IDX_W'(RIX_IMODE)) bus_rdata = imode_q;
      else if (widx == IDX_W'(RIX_IPOL))  bus_rdata = ipol_q;
      else if (widx == IDX_W'(RIX_ISTAT)) bus_rdata = istat;
      else if (widx == IDX_W'(RIX_GSEL))  bus_rdata = gsel_q;
      else if (widx == IDX_W'(RIX_GPOL))  bus_rdata = gpol_q;
      else if (widx == IDX_W'(RIX_GCTL))  bus_rdata = WIDTH'(gand_q);
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;

   assert_dir_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(widx, RIX_DIR, wr_en) && (&bus_be)) |=> (pad_oe == $past(bus_wdata)));

   assert_mask_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit(widx, RIX_MOUT, wr_en) |=> ((pad_out & $past(mask_q)) == ($past(pad_out) & $past(mask_q))));

   assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit(widx, RIX_SET, wr_en) |=> (((pad_out & $past(strobed)) == $past(strobed))
                                     && ((pad_out & ~$past(strobed)) == ($past(pad_out) & ~$past(strobed)))));

   assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit(widx, RIX_CLR, wr_en) |=> (((pad_out & $past(strobed)) == '0)
                                     && ((pad_out & ~$past(strobed)) == ($past(pad_out) & ~$past(strobed)))));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/10ps
module gpio_port_ctrl_tb;

   localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_IRQ = 3, K_GRP = 4;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pin_irq;
   logic        group_irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   sb_item_t sbq[$];
   event ev_sample;

   always #2 clk = ~clk;

   gpio_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pin_irq(pin_irq), .group_irq(group_irq)
   );

   // monitor: pops expected items and compares against the port
   initial begin
      forever begin
         sb_item_t it;
         logic [31:0] act;
         @(ev_sample);
         it = sbq.pop_front();
         case (it.kind)
            K_RD:    act = bus_rdata;
            K_OE:    act = pad_oe;
            K_OUT:   act = pad_out;
            K_IRQ:   act = pin_irq;
            default: act = {31'd0, group_irq};
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push(input int kind, input logic [5:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      bus_addr = a;
      #0.1;
      it.kind = kind; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      -> ev_sample;
      #0.1;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic pins(input logic [31:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   localparam logic [5:0] A_DIR = 6'h00, A_OUT = 6'h04, A_MASK = 6'h08, A_MOUT = 6'h0C,
                          A_SET = 6'h10, A_CLR = 6'h14, A_PIN = 6'h18, A_IEN = 6'h1C,
                          A_IMODE = 6'h20, A_IPOL = 6'h24, A_ISTAT = 6'h28,
                          A_GSEL = 6'h2C, A_GPOL = 6'h30, A_GCTL = 6'h34;

   initial begin
      #1000000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);
      // R1 reset state
      push(K_RD,  A_DIR, 32'h0, "R1 dir");
      push(K_RD,  A_OUT, 32'h0, "R1 out");
      push(K_OE,  A_DIR, 32'h0, "R1 pad_oe");
      push(K_IRQ, A_DIR, 32'h0, "R1 pin_irq");
      push(K_GRP, A_DIR, 32'h0, "R1 group_irq");
      // R2 direction
      wr(A_DIR, 32'hFFFF0000, 4'hF);
      push(K_OE, A_DIR, 32'hFFFF0000, "R2 pad_oe");
      // R3 whole and lane writes
      wr(A_OUT, 32'h12345678, 4'hF);
      push(K_RD,  A_OUT, 32'h12345678, "R3 full read");
      push(K_OUT, A_OUT, 32'h12345678, "R3 pad_out");
      wr(A_OUT, 32'hAABBCCDD, 4'b0100);
      push(K_RD, A_OUT, 32'h12BB5678, "R3 byte lane");
      wr(A_OUT, 32'h00009999, 4'b0011);
      push(K_RD, A_OUT, 32'h12BB9999, "R3 half word");
      // R4 masked write
      wr(A_MASK, 32'hFFFF0000, 4'hF);
      wr(A_MOUT, 32'h00000000, 4'hF);
      push(K_OUT, A_OUT, 32'h12BB0000, "R4 mask protects upper");
      wr(A_MOUT, 32'hFFFFFFFF, 4'b0001);
      push(K_OUT, A_OUT, 32'h12BB00FF, "R4 masked byte");
      // R5 set
      wr(A_SET, 32'h80000001, 4'hF);
      push(K_OUT, A_OUT, 32'h92BB00FF, "R5 set bits");
      wr(A_SET, 32'hFF00FF00, 4'b0001);
      push(K_OUT, A_OUT, 32'h92BB00FF, "R5 zeros and unstrobed ignored");
      // R6 clear
      wr(A_CLR, 32'h000000F0, 4'hF);
      push(K_OUT, A_OUT, 32'h92BB000F, "R6 clear bits");
      wr(A_CLR, 32'hFFFFFFFF, 4'b1000);
      push(K_OUT, A_OUT, 32'h00BB000F, "R6 clear upper lane");
      // R7 readback delay
      pins(32'hA5A50F0F);
      wait_neg(1);
      push(K_RD, A_PIN, 32'h0, "R7 one edge early");
      wait_neg(1);
      push(K_RD, A_PIN, 32'hA5A50F0F, "R7 pin level");
      // R8 edge interrupts, rising
      wr(A_IPOL, 32'h1, 4'hF);
      wr(A_IEN, 32'h1, 4'hF);
      pins(32'hA5A50F0E);
      wait_neg(3);
      push(K_RD, A_ISTAT, 32'h0, "R8 wrong edge ignored");
      pins(32'hA5A50F0F);
      wait_neg(2);
      push(K_IRQ, A_ISTAT, 32'h0, "R8 one edge early");
      wait_neg(1);
      push(K_IRQ, A_ISTAT, 32'h1, "R8 rising irq");
      push(K_RD,  A_ISTAT, 32'h1, "R8 rising status");
      pins(32'hA5A50F0E);
      wait_neg(3);
      push(K_RD, A_ISTAT, 32'h1, "R8 sticky");
      wr(A_ISTAT, 32'h1, 4'hF);
      push(K_RD, A_ISTAT, 32'h0, "R8 w1c");
      // R8 falling polarity
      wr(A_IPOL, 32'h0, 4'hF);
      pins(32'hA5A50F0F);
      wait_neg(3);
      push(K_RD, A_ISTAT, 32'h0, "R8 rise ignored in falling mode");
      pins(32'hA5A50F0E);
      wait_neg(3);
      push(K_RD, A_ISTAT, 32'h1, "R8 falling status");
      // R12 enable gating
      wr(A_IEN, 32'h0, 4'hF);
      push(K_IRQ, A_ISTAT, 32'h0, "R12 disabled irq");
      push(K_RD,  A_ISTAT, 32'h1, "R12 status kept");
      wr(A_ISTAT, 32'h1, 4'hF);
      // R9 level interrupts on pin 1 (high now)
      wr(A_IMODE, 32'h2, 4'hF);
      wr(A_IPOL, 32'h2, 4'hF);
      wr(A_IEN, 32'h2, 4'hF);
      push(K_IRQ, A_ISTAT, 32'h2, "R9 level high");
      push(K_RD,  A_ISTAT, 32'h2, "R9 level status");
      pins(32'hA5A50F0C);
      wait_neg(2);
      push(K_IRQ, A_ISTAT, 32'h0, "R9 level follows low");
      pins(32'hA5A50F0E);
      wait_neg(2);
      push(K_IRQ, A_ISTAT, 32'h2, "R9 level follows high");
      wr(A_IEN, 32'h0, 4'hF);
      push(K_IRQ, A_ISTAT, 32'h0, "R12 level disabled");
      // R10 group OR on pins 4,5
      wr(A_GSEL, 32'h30, 4'hF);
      wr(A_GPOL, 32'h30, 4'hF);
      wr(A_GCTL, 32'h0, 4'hF);
      push(K_GRP, A_GCTL, 32'h0, "R10 none active");
      pins(32'hA5A50F1E);
      wait_neg(2);
      push(K_GRP, A_GCTL, 32'h1, "R10 one active");
      // R11 group AND
      wr(A_GCTL, 32'h1, 4'hF);
      push(K_GRP, A_GCTL, 32'h0, "R11 partial");
      pins(32'hA5A50F3E);
      wait_neg(2);
      push(K_GRP, A_GCTL, 32'h1, "R11 all active");
      wr(A_GPOL, 32'h10, 4'hF);
      push(K_GRP, A_GCTL, 32'h0, "R11 polarity low");
      wr(A_GPOL, 32'h30, 4'hF);
      push(K_GRP, A_GCTL, 32'h1, "R11 restored");
      wr(A_GSEL, 32'h0, 4'hF);
      push(K_GRP, A_GCTL, 32'h0, "R11 empty selection");
      wait_neg(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule